// File: doc/BRIEF.md
# Dual-Channel Converter Serial Command Decoder

This block is the digital front end of a two-channel voltage-output converter. A host sends command frames over a three-wire serial link made of an active-low select/load line, a serial clock and a data line. Each bit is sampled on a rising serial clock edge while select is low. Clock edges that arrive while select is high have no effect. When select returns high, the frame is closed. The captured word crosses into the system clock domain and is executed there.

Each channel keeps two registers and a sleep flag. A pending (input) register takes new codes. An active register holds the code the analog stage converts. The sleep flag tells the analog stage to shut down. Writing a pending register and moving it to the active register are separate operations, so a host can stage new codes and make them take effect together. The code width is a parameter of 12, 14 or 16 bits. The code is left-aligned in a 16-bit data field.

Top module: `dual_dac_cmd_decoder`

## Requirements
- R1: After reset, both active codes read zero and both sleep outputs read 0. The pending registers also clear to zero.
- R2: A frame is sent most significant bit first. It carries a 4-bit command, then a 4-bit address, then a 16-bit data field. The code occupies the top CODE_W bits of the data field, and the remaining low bits are ignored.
- R3: Serial clock edges that occur while cs_n is high change no register and no output.
- R4: A frame of 32 clock edges is accepted. Only the last 24 bits shifted before cs_n rises are decoded, so 8 leading bits are ignored.
- R5: A frame of fewer than 24 clock edges is dropped when cs_n rises, and no register changes.
- R6: Command 0000 loads the pending register of the addressed channel and leaves the active code unchanged. Command 0001 copies the pending register to the active code of the addressed channel and clears its sleep flag.
- R7: Command 0011 loads both the pending register and the active code of the addressed channel with the frame code, and clears that channel's sleep flag.
- R8: Command 0010 loads the addressed pending register with the frame code. It then copies both pending registers to the active codes and clears both sleep flags.
- R9: Command 0100 sets the sleep flag of the addressed channel, ignores the data field and keeps both register contents. A later update command clears the flag again.
- R10: Address 0000 selects channel A, 0001 selects channel B and 1111 selects both channels.
- R11: Command 1111, any command code not listed above, and any address other than 0000, 0001 and 1111 change no register.
- R12: An executed frame changes the outputs on the third rising clk edge after cs_n rises. The outputs hold at every other clk edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low select; its rising edge closes and executes the frame |
| sclk | input | 1 | Serial clock; data is sampled on its rising edge |
| sdi | input | 1 | Serial data input |
| code_a | output | CODE_W | Active code of channel A |
| code_b | output | CODE_W | Active code of channel B |
| sleep_a | output | 1 | Channel A power-down state |
| sleep_b | output | 1 | Channel B power-down state |

## Verification
Assertions check the following on every system clock cycle:
- Outputs hold whenever no execute strobe is pending.
- A short frame, a reserved command or a reserved address leaves the outputs untouched.
- A sleep command sets the flag and keeps the code.
- Write-and-update and update-all commands leave the addressed channels awake, with the frame's code where the command loads it.

Only the bench scenarios can show the following:
- The serial side: bit order, code alignment, edges ignored while select is high, and the selection of the last 24 bits of a 32-bit frame.
- The staging through the pending registers, which is visible only after a later update command.
- The exact three-cycle execution latency.

// File: rtl/dual_dac_cmd_decoder.sv
module dual_dac_cmd_decoder #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [CODE_W-1:0] code_a,
  output logic [CODE_W-1:0] code_b,
  output logic              sleep_a,
  output logic              sleep_b
);
  localparam int WORD_W = 24;
  localparam int KEEP_W = 8 + CODE_W;
  localparam int CNT_W  = 6;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(32);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(WORD_W);

  localparam logic [3:0] OP_WR   = 4'h0;
  localparam logic [3:0] OP_UPD  = 4'h1;
  localparam logic [3:0] OP_WUA  = 4'h2;
  localparam logic [3:0] OP_WU   = 4'h3;
  localparam logic [3:0] OP_PD   = 4'h4;
  localparam logic [3:0] AD_A    = 4'h0;
  localparam logic [3:0] AD_B    = 4'h1;
  localparam logic [3:0] AD_BOTH = 4'hF;

  initial assert (CODE_W == 12 || CODE_W == 14 || CODE_W == 16)
    else $error("CODE_W must be 12, 14 or 16");

  // serial clock side
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bitcnt;
  logic [KEEP_W-1:0] frame;
  logic              frame_ok;
  logic              frame_tgl;

  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n)     shreg <= '0;
    else if (!cs_n) shreg <= {shreg[WORD_W-2:0], sdi};
  end

  always_ff @(posedge sclk or posedge cs_n or negedge rst_n) begin
    if (!rst_n)                bitcnt <= '0;
    else if (cs_n)             bitcnt <= '0;
    else if (bitcnt != CNT_MAX) bitcnt <= bitcnt + 1'b1;
  end

  always_ff @(posedge cs_n or negedge rst_n) begin
    if (!rst_n) begin
      frame     <= '0;
      frame_ok  <= 1'b0;
      frame_tgl <= 1'b0;
    end else begin
      frame     <= shreg[WORD_W-1 -: KEEP_W];
      frame_ok  <= (bitcnt >= CNT_MIN);
      frame_tgl <= ~frame_tgl;
    end
  end

  // system clock side
  logic [2:0] sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '0;
    else        sync <= {sync[1:0], frame_tgl};
  end

  logic              exec;
  logic [3:0]        op, adr;
  logic [CODE_W-1:0] fcode;
  logic [1:0]        hit;
  logic              go;

  assign exec   = sync[2] ^ sync[1];
  assign op     = frame[KEEP_W-1 -: 4];
  assign adr    = frame[KEEP_W-5 -: 4];
  assign fcode  = frame[CODE_W-1:0];
  assign hit[0] = (adr == AD_A) || (adr == AD_BOTH);
  assign hit[1] = (adr == AD_B) || (adr == AD_BOTH);
  assign go     = exec && frame_ok && (hit != 2'b00);

  logic [CODE_W-1:0] pend [2];
  logic [CODE_W-1:0] act  [2];
  logic [1:0]        sleep;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 2; c++) begin
        pend[c] <= '0;
        act[c]  <= '0;
      end
      sleep <= '0;
    end else if (go) begin
      for (int c = 0; c < 2; c++) begin
        case (op)
          OP_WR:  if (hit[c]) pend[c] <= fcode;
          OP_UPD: if (hit[c]) begin act[c] <= pend[c]; sleep[c] <= 1'b0; end
          OP_WUA: begin
            if (hit[c]) pend[c] <= fcode;
            act[c]   <= hit[c] ? fcode : pend[c];
            sleep[c] <= 1'b0;
          end
          OP_WU:  if (hit[c]) begin pend[c] <= fcode; act[c] <= fcode; sleep[c] <= 1'b0; end
          OP_PD:  if (hit[c]) sleep[c] <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  assign code_a  = act[0];
  assign code_b  = act[1];
  assign sleep_a = sleep[0];
  assign sleep_b = sleep[1];

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !exec |=> ($stable(code_a) && $stable(code_b) && $stable(sleep_a) && $stable(sleep_b)));

  // R5
  short_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !frame_ok) |=> ($stable(code_a) && $stable(code_b) && $stable(sleep_a) && $stable(sleep_b)));

  // R11
  reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && (op > OP_PD || !(hit[0] || hit[1])))
      |=> ($stable(code_a) && $stable(code_b) && $stable(sleep_a) && $stable(sleep_b)));

  // R9
  sleep_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_PD && hit[0]) |=> (sleep_a && $stable(code_a)));

  // R7
  wr_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_WU && hit[1]) |=> (!sleep_b && code_b == $past(fcode)));

  // R8
  upd_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go && op == OP_WUA) |=> (!sleep_a && !sleep_b));
endmodule

// File: tb/dual_dac_cmd_decoder_bench.sv
module dual_dac_cmd_decoder_bench;
  localparam int CW = 12;
  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic [CW-1:0] code_a, code_b;
  logic sleep_a, sleep_b;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dual_dac_cmd_decoder #(.CODE_W(CW)) u_dual_dac_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .code_a(code_a), .code_b(code_b), .sleep_a(sleep_a), .sleep_b(sleep_b));

  function automatic logic [31:0] mk(input logic [3:0] op, input logic [3:0] ad,
                                     input logic [CW-1:0] c, input logic [3:0] pad);
    return {8'h00, op, ad, c, pad};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [31:0] w, input int n);
    cs_n = 0;
    #7;
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i];
      #8 sclk = 1;
      #8 sclk = 0;
    end
    #6;
  endtask

  task automatic send(input logic [31:0] w, input int n);
    shift_bits(w, n);
    cs_n = 1;
    repeat (6) @(posedge clk);
    #2;
  endtask

  task automatic expect_state(input string req, input logic [CW-1:0] ea, input logic [CW-1:0] eb,
                              input logic sa, input logic sb);
    chk(req, 32'(code_a), 32'(ea));
    chk(req, 32'(code_b), 32'(eb));
    chk(req, 32'(sleep_a), 32'(sa));
    chk(req, 32'(sleep_b), 32'(sb));
  endtask

  task automatic t_reset;
    // R1
    expect_state("R1 reset", 0, 0, 0, 0);
  endtask

  task automatic t_stage_update;
    send(mk(4'h0, 4'h0, 12'h123, 4'h0), 24);
    expect_state("R6 write only stages", 0, 0, 0, 0);
    send(mk(4'h1, 4'h0, 12'hFFF, 4'hF), 24);
    expect_state("R6 update copies pending R2", 12'h123, 0, 0, 0);
  endtask

  task automatic t_write_update_b;
    send(mk(4'h3, 4'h1, 12'hABC, 4'hF), 24);
    expect_state("R7 R10 R2 write+update B", 12'h123, 12'hABC, 0, 0);
  endtask

  task automatic t_idle_edges;
    cs_n = 1;
    for (int i = 0; i < 30; i++) begin
      sdi = i[0];
      #8 sclk = 1;
      #8 sclk = 0;
    end
    repeat (6) @(posedge clk);
    #2;
    expect_state("R3 edges with select high", 12'h123, 12'hABC, 0, 0);
  endtask

  task automatic t_short;
    send(mk(4'h3, 4'h0, 12'hFFF, 4'h0), 23);
    expect_state("R5 short frame dropped", 12'h123, 12'hABC, 0, 0);
  endtask

  task automatic t_long;
    send({8'hA5, mk(4'h3, 4'h1, 12'h3C3, 4'h5)} | 32'hA500_0000, 32);
    expect_state("R4 32-bit frame", 12'h123, 12'h3C3, 0, 0);
  endtask

  task automatic t_write_all;
    send(mk(4'h0, 4'h1, 12'h777, 4'h0), 24);
    expect_state("R8 stage B", 12'h123, 12'h3C3, 0, 0);
    send(mk(4'h2, 4'h0, 12'h111, 4'h0), 24);
    expect_state("R8 write A update all", 12'h111, 12'h777, 0, 0);
  endtask

  task automatic t_sleep;
    send(mk(4'h4, 4'h1, 12'h000, 4'h0), 24);
    expect_state("R9 sleep B keeps code", 12'h111, 12'h777, 0, 1);
    send(mk(4'h4, 4'hF, 12'h5A5, 4'h0), 24);
    expect_state("R9 R10 sleep both", 12'h111, 12'h777, 1, 1);
    send(mk(4'h1, 4'hF, 12'h000, 4'h0), 24);
    expect_state("R9 R10 update wakes both", 12'h111, 12'h777, 0, 0);
  endtask

  task automatic t_reserved;
    send(mk(4'h5, 4'h0, 12'hFFF, 4'h0), 24);
    expect_state("R11 reserved command", 12'h111, 12'h777, 0, 0);
    send(mk(4'h3, 4'h2, 12'hFFF, 4'h0), 24);
    expect_state("R11 reserved address", 12'h111, 12'h777, 0, 0);
    send(mk(4'h2, 4'h7, 12'hFFF, 4'h0), 24);
    expect_state("R11 reserved address update-all", 12'h111, 12'h777, 0, 0);
    send(mk(4'hF, 4'hF, 12'hFFF, 4'h0), 24);
    expect_state("R11 no-op", 12'h111, 12'h777, 0, 0);
    send(mk(4'h1, 4'h0, 12'h000, 4'h0), 24);
    expect_state("R11 pending untouched", 12'h111, 12'h777, 0, 0);
  endtask

  task automatic t_latency;
    shift_bits(mk(4'h3, 4'h0, 12'h246, 4'h0), 24);
    @(negedge clk);
    cs_n = 1;
    @(posedge clk); #2;
    chk("R12 after edge 1", 32'(code_a), 32'h111);
    @(posedge clk); #2;
    chk("R12 after edge 2", 32'(code_a), 32'h111);
    @(posedge clk); #2;
    chk("R12 after edge 3", 32'(code_a), 32'h246);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;
    t_reset();
    t_stage_update();
    t_write_update_b();
    t_idle_edges();
    t_short();
    t_long();
    t_write_all();
    t_sleep();
    t_reserved();
    t_latency();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        #1ms;
        checks++;
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule